// File: doc/BRIEF.md
# USB Endpoint Control Register Bank

This block holds the per-endpoint control and status words of a full-speed USB device controller. There are eight 16-bit words, one for each endpoint. A CPU reaches them through a plain word-wide port. The USB protocol engine reaches them through per-endpoint event strobes. Those strobes report received or transmitted transfers, SETUP receptions, data-toggle advances and status-field updates.

Each field has a write rule chosen so that software never needs a read-modify-write sequence:

- **Completion flags.** They are set only by hardware. A CPU write of 0 clears a flag and a write of 1 leaves it alone.
- **Sequence and mode fields.** A written 1 inverts a bit and a written 0 leaves it alone.
- **SETUP marker.** It is read-only to the CPU.
- **Transfer kind, option bit and endpoint address.** These are ordinary storage.

Because every field that hardware can change has a value that means "no change", a store can update the storage fields without disturbing anything hardware owns. A USB bus reset or a forced reset clears every field except the two completion flags. This keeps a transfer that finishes just before a reset from being lost.

The CPU port is a simple command/response path with no back-pressure. A write takes effect on the clock edge where `cpu_wr` is high. A read is combinational and always available. Word `n` sits at byte offset `4*n`.

Top module: `usb_ep_regbank`

## Requirements
- R1: After `rst_n` is released, all eight words read 0x0000.
- R2: Bit 15 (receive complete) and bit 7 (transmit complete) of a word clear when the CPU writes 0 to them. Writing 1 to them leaves them unchanged.
- R3: `hw_rx_done[n]` sets bit 15 of word n, and `hw_tx_done[n]` sets bit 7 of word n, on the next edge. This holds even when a CPU clear of that bit happens in the same cycle.
- R4: A CPU write of 1 to bit 14, 13, 12, 6, 5 or 4 inverts that bit. Writing 0 there leaves it unchanged.
- R5: The hardware toggle inputs combine with a same-cycle CPU toggle by XOR, so two toggles of one bit in one cycle leave it unchanged. The inputs are `hw_rx_seq_tgl` for bit 14, `hw_tx_seq_tgl` for bit 6, `hw_rx_mode_tgl` for bits 13:12 and `hw_tx_mode_tgl` for bits 5:4.
- R6: Bit 11 (SETUP marker) ignores CPU writes. When `hw_rx_done[n]` is high, bit 11 takes the value of `hw_rx_setup[n]`. Otherwise bit 11 holds.
- R7: Bits 10:9 (transfer kind), bit 8 (option) and bits 3:0 (endpoint address) store the CPU write data.
- R8: A cycle with `bus_rst` or `force_rst` high clears every bit except 15 and 7. Bits 15 and 7 follow only R2 and R3.
- R9: `cpu_rdata` gives the addressed word in the same cycle. A byte offset that is not a multiple of 4 reads 0. An offset of 0x20 or above reads 0. Writes to either kind of offset change no word.
- R10: A write whose data is 1 in bits 15 and 7 and 0 in the toggle bits changes only the storage fields of R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rst | input | 1 | USB bus reset seen on the line |
| force_rst | input | 1 | Reset forced by software control |
| cpu_addr | input | 6 | Byte offset of the accessed word |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data for `cpu_addr` |
| hw_rx_done | input | 8 | Receive transfer completed, one bit per endpoint |
| hw_rx_setup | input | 8 | Qualifies `hw_rx_done` as a SETUP reception |
| hw_tx_done | input | 8 | Transmit transfer completed, one bit per endpoint |
| hw_rx_seq_tgl | input | 8 | Advance the receive data toggle |
| hw_tx_seq_tgl | input | 8 | Advance the transmit data toggle |
| hw_rx_mode_tgl | input | 16 | Inversion mask for receive status, 2 bits per endpoint |
| hw_tx_mode_tgl | input | 16 | Inversion mask for transmit status, 2 bits per endpoint |

## Verification
Two kinds of update can land on the same bit in one cycle. The first is a hardware completion strobe arriving with a CPU clear of that flag. The second is a hardware toggle or status mask arriving with a CPU toggle write to the same bit. The bench forces both collisions with directed single-cycle stimuli, and a long pseudo-random sweep keeps producing them, together with resets and accesses to unmapped offsets. After each edge, all eight words are read back and compared with a model built from the requirements. Under that model the first collision must leave the flag set and the second must leave the bit unchanged.

// File: rtl/usb_ep_regbank_pkg.sv
package usb_ep_regbank_pkg;
  localparam int WORD_W = 16;

  // Field order matches the bit positions software decodes, MSB first.
  typedef struct packed {
    logic       rx_cmpl;     // 15
    logic       rx_seq;      // 14
    logic [1:0] rx_mode;     // 13:12
    logic       setup_seen;  // 11
    logic [1:0] xfer_kind;   // 10:9
    logic       aux_opt;     // 8
    logic       tx_cmpl;     // 7
    logic       tx_seq;      // 6
    logic [1:0] tx_mode;     // 5:4
    logic [3:0] dev_ep_addr; // 3:0
  } ep_word_t;

  localparam logic [WORD_W-1:0] KEEP_ON_RST = 16'h8080;
endpackage

// File: rtl/usb_ep_addr_dec.sv
module usb_ep_addr_dec #(
  parameter int NEP    = 8,
  parameter int ADDR_W = 6,
  localparam int IDX_W = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx,
  output logic [NEP-1:0]    wr_sel
);
  assign idx = addr[ADDR_W-1:2];
  assign hit = (addr[1:0] == 2'b00) && (32'(idx) < NEP);

  for (genvar g = 0; g < NEP; g++) begin : g_sel
    assign wr_sel[g] = wr && hit && (32'(idx) == g);
  end
endmodule

// File: rtl/usb_ep_slot.sv
module usb_ep_slot
  import usb_ep_regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_cfg,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  input  logic              ev_rx_done,
  input  logic              ev_rx_setup,
  input  logic              ev_tx_done,
  input  logic              ev_rx_seq,
  input  logic              ev_tx_seq,
  input  logic [1:0]        ev_rx_mode,
  input  logic [1:0]        ev_tx_mode,
  output logic [WORD_W-1:0] word_q
);
  ep_word_t q, nxt, wd;
  assign wd     = ep_word_t'(wdata);
  assign word_q = q;

  always_comb begin
    nxt = q;
    // Completion flags: hardware set dominates a CPU clear.
    nxt.rx_cmpl = ev_rx_done | (q.rx_cmpl & ~(wr_en & ~wd.rx_cmpl));
    nxt.tx_cmpl = ev_tx_done | (q.tx_cmpl & ~(wr_en & ~wd.tx_cmpl));
    if (clr_cfg) begin
      nxt.rx_seq      = 1'b0;
      nxt.rx_mode     = 2'b00;
      nxt.setup_seen  = 1'b0;
      nxt.xfer_kind   = 2'b00;
      nxt.aux_opt     = 1'b0;
      nxt.tx_seq      = 1'b0;
      nxt.tx_mode     = 2'b00;
      nxt.dev_ep_addr = 4'h0;
    end else begin
      nxt.rx_seq  = q.rx_seq ^ (wr_en & wd.rx_seq) ^ ev_rx_seq;
      nxt.tx_seq  = q.tx_seq ^ (wr_en & wd.tx_seq) ^ ev_tx_seq;
      nxt.rx_mode = q.rx_mode ^ ({2{wr_en}} & wd.rx_mode) ^ ev_rx_mode;
      nxt.tx_mode = q.tx_mode ^ ({2{wr_en}} & wd.tx_mode) ^ ev_tx_mode;
      if (ev_rx_done) nxt.setup_seen = ev_rx_setup;
      if (wr_en) begin
        nxt.xfer_kind   = wd.xfer_kind;
        nxt.aux_opt     = wd.aux_opt;
        nxt.dev_ep_addr = wd.dev_ep_addr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  // R3
  rx_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_done |=> q.rx_cmpl);
  // R3
  tx_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_done |=> q.tx_cmpl);
  // R2
  rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wd.rx_cmpl && !ev_rx_done) |=> !q.rx_cmpl);
  // R8
  rst_keeps_cmpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_cfg && !wr_en && !ev_rx_done && !ev_tx_done)
      |=> ($stable(q.rx_cmpl) && $stable(q.tx_cmpl)));
  // R8
  rst_clears_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cfg |=> ((word_q & ~KEEP_ON_RST) == '0));
  // R6
  setup_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_rx_done && !clr_cfg) |=> $stable(q.setup_seen));
  // R5
  seq_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wd.rx_seq && ev_rx_seq && !clr_cfg) |=> $stable(q.rx_seq));
endmodule

// File: rtl/usb_ep_regbank.sv
module usb_ep_regbank
  import usb_ep_regbank_pkg::*;
#(
  parameter int NEP    = 8,
  parameter int ADDR_W = 6,
  localparam int IDX_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rst,
  input  logic              force_rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic [WORD_W-1:0] cpu_rdata,
  input  logic [NEP-1:0]    hw_rx_done,
  input  logic [NEP-1:0]    hw_rx_setup,
  input  logic [NEP-1:0]    hw_tx_done,
  input  logic [NEP-1:0]    hw_rx_seq_tgl,
  input  logic [NEP-1:0]    hw_tx_seq_tgl,
  input  logic [2*NEP-1:0]  hw_rx_mode_tgl,
  input  logic [2*NEP-1:0]  hw_tx_mode_tgl
);
  logic             rd_hit;
  logic [IDX_W-1:0] rd_idx;
  logic [NEP-1:0]   wr_sel;
  logic             clr_cfg;
  logic [WORD_W-1:0] words [NEP];

  assign clr_cfg = bus_rst | force_rst;

  usb_ep_addr_dec #(.NEP(NEP), .ADDR_W(ADDR_W)) u_dec (
    .addr(cpu_addr), .wr(cpu_wr), .hit(rd_hit), .idx(rd_idx), .wr_sel(wr_sel)
  );

  for (genvar g = 0; g < NEP; g++) begin : g_ep
    usb_ep_slot u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_cfg    (clr_cfg),
      .wr_en      (wr_sel[g]),
      .wdata      (cpu_wdata),
      .ev_rx_done (hw_rx_done[g]),
      .ev_rx_setup(hw_rx_setup[g]),
      .ev_tx_done (hw_tx_done[g]),
      .ev_rx_seq  (hw_rx_seq_tgl[g]),
      .ev_tx_seq  (hw_tx_seq_tgl[g]),
      .ev_rx_mode (hw_rx_mode_tgl[2*g +: 2]),
      .ev_tx_mode (hw_tx_mode_tgl[2*g +: 2]),
      .word_q     (words[g])
    );
  end

  always_comb begin
    cpu_rdata = '0;
    for (int i = 0; i < NEP; i++)
      if (rd_hit && (32'(rd_idx) == i)) cpu_rdata = words[i];
  end

  // R9
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !rd_hit) |-> (wr_sel == '0));
endmodule

// File: tb/usb_ep_regbank_tb.sv
module usb_ep_regbank_tb;
  localparam int CLK_P = 20;
  localparam int NEP   = 8;

  logic clk = 0, rst_n = 0, bus_rst = 0, force_rst = 0, cpu_wr = 0;
  logic [5:0]  cpu_addr = 0;
  logic [15:0] cpu_wdata = 0, cpu_rdata;
  logic [7:0]  hw_rx_done = 0, hw_rx_setup = 0, hw_tx_done = 0;
  logic [7:0]  hw_rx_seq_tgl = 0, hw_tx_seq_tgl = 0;
  logic [15:0] hw_rx_mode_tgl = 0, hw_tx_mode_tgl = 0;

  int checks = 0, failures = 0;
  logic [15:0] expw [NEP];

  always #(CLK_P/2) clk = ~clk;

  usb_ep_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .force_rst(force_rst),
    .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .hw_rx_done(hw_rx_done), .hw_rx_setup(hw_rx_setup),
    .hw_tx_done(hw_tx_done), .hw_rx_seq_tgl(hw_rx_seq_tgl),
    .hw_tx_seq_tgl(hw_tx_seq_tgl), .hw_rx_mode_tgl(hw_rx_mode_tgl),
    .hw_tx_mode_tgl(hw_tx_mode_tgl)
  );

  task automatic chk(input string lbl, input logic [15:0] got, input logic [15:0] want);
    checks++;
    if (got !== want) begin
      failures++;
      $display("FAIL %s got=%04h exp=%04h", lbl, got, want);
    end
  endtask

  // Expected next value, from the field rules in the requirements.
  function automatic logic [15:0] model(input logic [15:0] c, input logic w,
      input logic [15:0] d, input logic rxd, stp, txd, rxs, txs,
      input logic [1:0] rxm, txm, input logic r);
    logic [15:0] n;
    n = c;
    n[15] = rxd | (c[15] & ~(w & ~d[15]));               // R2 R3
    n[7]  = txd | (c[7]  & ~(w & ~d[7]));
    if (r) n = n & 16'h8080;                              // R8
    else begin
      n[14]    = c[14] ^ (w & d[14]) ^ rxs;               // R4 R5
      n[6]     = c[6]  ^ (w & d[6])  ^ txs;
      n[13:12] = c[13:12] ^ ({2{w}} & d[13:12]) ^ rxm;
      n[5:4]   = c[5:4]   ^ ({2{w}} & d[5:4])   ^ txm;
      if (rxd) n[11] = stp;                               // R6
      if (w) begin n[10:8] = d[10:8]; n[3:0] = d[3:0]; end // R7
    end
    return n;
  endfunction

  task automatic readall(input string lbl);
    for (int e = 0; e < NEP; e++) begin
      cpu_addr = 6'(e*4); #1;
      chk(lbl, cpu_rdata, expw[e]);
    end
    cpu_addr = 6'h22; #1; chk({lbl, " R9 out-of-range read"}, cpu_rdata, 16'h0);
    cpu_addr = 6'h06; #1; chk({lbl, " R9 unaligned read"}, cpu_rdata, 16'h0);
  endtask

  task automatic step(input string lbl, input logic w, input logic [5:0] a,
      input logic [15:0] d, input logic [7:0] rxd, stp, txd, rxs, txs,
      input logic [15:0] rxm, txm, input logic br, fr);
    cpu_wr = w; cpu_addr = a; cpu_wdata = d;
    hw_rx_done = rxd; hw_rx_setup = stp; hw_tx_done = txd;
    hw_rx_seq_tgl = rxs; hw_tx_seq_tgl = txs;
    hw_rx_mode_tgl = rxm; hw_tx_mode_tgl = txm;
    bus_rst = br; force_rst = fr;
    for (int e = 0; e < NEP; e++)
      expw[e] = model(expw[e], w && a[1:0] == 2'b00 && a[5:2] == 4'(e), d,
                      rxd[e], stp[e], txd[e], rxs[e], txs[e],
                      rxm[2*e +: 2], txm[2*e +: 2], br | fr);
    @(posedge clk); #1;
    cpu_wr = 0; hw_rx_done = 0; hw_rx_setup = 0; hw_tx_done = 0;
    hw_rx_seq_tgl = 0; hw_tx_seq_tgl = 0; hw_rx_mode_tgl = 0;
    hw_tx_mode_tgl = 0; bus_rst = 0; force_rst = 0;
    readall(lbl);
  endtask

  task automatic wr(input string lbl, input logic [5:0] a, input logic [15:0] d);
    step(lbl, 1'b1, a, d, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_P*100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] s;
    for (int e = 0; e < NEP; e++) expw[e] = 16'h0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    readall("R1 reset value");

    wr("R7 storage fields", 6'h08, 16'h8F8F);
    wr("R4 toggle bits invert", 6'h08, 16'h7070);
    wr("R4 zeros keep toggles", 6'h08, 16'h8080);
    step("R3 hw rx/tx done", 0, 0, 0, 8'h04, 0, 8'h04, 0, 0, 0, 0, 0, 0);
    wr("R2 write 1 keeps flags", 6'h08, 16'h8080);
    wr("R2 write 0 clears flags", 6'h08, 16'h0000);
    step("R3 set beats clear", 1, 6'h08, 16'h0000, 8'h04, 0, 8'h04, 0, 0, 0, 0, 0, 0);
    step("R5 toggle collision cancels", 1, 6'h08, 16'h9050, 0, 0, 0,
         8'h04, 8'h04, 16'h0030, 16'h0010, 0, 0);
    step("R6 setup reception", 0, 0, 0, 8'h10, 8'h10, 0, 0, 0, 0, 0, 0, 0);
    wr("R6 setup ignores cpu", 6'h10, 16'h0000);
    step("R6 setup cleared by data rx", 0, 0, 0, 8'h10, 0, 0, 0, 0, 0, 0, 0, 0);
    wr("R10 invariant write", 6'h1C, 16'h8085);
    wr("R9 unmapped write", 6'h20, 16'h7FFF);
    wr("R9 unaligned write", 6'h1D, 16'h7FFF);
    wr("R8 prep", 6'h0C, 16'h7FFF);
    step("R8 prep flags", 0, 0, 0, 8'h08, 0, 8'h08, 0, 0, 0, 0, 0, 0);
    step("R8 bus reset", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    wr("R8 prep2", 6'h0C, 16'h7FFF);
    step("R8 forced reset with write", 1, 6'h0C, 16'h7FFF, 0, 0, 0, 0, 0, 0, 0, 0, 1);

    s = 32'h1234_5678;
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r1, r2, r3;
      s ^= s << 13; s ^= s >> 17; s ^= s << 5; r1 = s;
      s ^= s << 13; s ^= s >> 17; s ^= s << 5; r2 = s;
      s ^= s << 13; s ^= s >> 17; s ^= s << 5; r3 = s;
      step("R2 R3 R4 R5 R6 R7 R8 R9 sweep", r1[0], r1[6:1], r1[31:16],
           r2[7:0] & r2[15:8], r2[23:16], r2[31:24] & r3[7:0],
           r3[15:8] & r1[15:8], r3[23:16] & r2[15:8], r2[15:0] & r3[31:16],
           r3[15:0] & r1[31:16], r1[13:7] == 0, r3[31:26] == 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule